// File: doc/BRIEF.md
# Paged Memory Window Address Decoder

This block decodes the address bus of an 8-bit CPU with a 16-bit address space. It opens a 4 KB window at $9000–$9FFF. A bank latch picks one of sixteen 4 KB pages of a 64 KB expansion RAM for that window. A control bit can replace the RAM in the window with a dedicated ROM socket. A second control bit write-protects the windowed RAM.

The block also produces chip selects for four 4 KB motherboard ROM sockets, a four-register serial controller and a single aliased peripheral register. An active-low strap can swap the motherboard ROM sockets for a parallel set of expansion ROM sockets. Addresses of the form $EFEx with x even enable a bridge between the RAM-side data bus and the CPU data bus.

Decoding is combinational from the address. The control registers load on the falling edge of the bus clock. The RAM write strobe is only asserted while the bus clock is high.

Top module: `bankwin_decoder`

## Requirements
- R1: After reset the bank is 0, the window shows RAM (ROM select 0), and write protection is off. A read at $9000–$9FFF then asserts `xram_cs` and `xram_oe` with `xram_addr_hi` = 0, and a write there asserts `xram_we`.
- R2: A write to $EFFC loads data bits 3:0 into the bank latch on the falling clock edge. Every later window RAM access in the following cycles drives that value on `xram_addr_hi`.
- R3: A write to $EFFE sets the window source from data bit 0: 1 selects the window ROM and 0 selects the banked RAM. In ROM mode a window access asserts only `winrom_cs`, for both reads and writes.
- R4: Data bit 1 of a write to $EFFE is the write-protect flag. While it is set, a window RAM write asserts `xram_cs` but never `xram_we`, and the RAM keeps its contents.
- R5: A window RAM read asserts `xram_oe` and not `xram_we`. A window RAM write asserts `xram_we` while the clock is high and never while it is low.
- R6: Pages $A–$D select ROM socket 0–3 (socket index = page − $A). With `rom_dis_n` high, `mbrom_cs` carries that select. With `rom_dis_n` low, `exprom_cs` carries it instead and `mbrom_cs` stays 0.
- R7: Any address in $EFF0–$EFF3 asserts `preg_cs`; A1:A0 have no effect on it.
- R8: Addresses $EFF8–$EFFB assert `serial_cs`, and `serial_rs` always equals A1:A0.
- R9: `bridge_en` is 1 exactly for $EFE0, $EFE2, …, $EFEE and 0 for any other address, including the odd $EFEx addresses.
- R10: At most one of the chip selects and `bridge_en` is active at once. $0000–$8FFF, pages $E and $F outside the decoded I/O addresses, and the register addresses $EFFC/$EFFE assert none of them.
- R11: Reads of $EFFC or $EFFE leave the bank and control bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; high phase is the valid access phase, falling edge loads registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_we | input | 1 | 1 = write cycle, 0 = read cycle |
| cpu_wdata | input | 8 | CPU write data |
| rom_dis_n | input | 1 | Active-low strap swapping motherboard ROMs for expansion ROMs |
| xram_addr_hi | output | 4 | Bank number used as upper expansion RAM address bits |
| xram_cs | output | 1 | Expansion RAM select for a window access |
| xram_oe | output | 1 | Expansion RAM output enable (window read) |
| xram_we | output | 1 | Expansion RAM write strobe, high phase only |
| winrom_cs | output | 1 | Window ROM socket select |
| mbrom_cs | output | 4 | Motherboard ROM socket selects, pages $A–$D |
| exprom_cs | output | 4 | Expansion ROM socket selects, pages $A–$D |
| serial_cs | output | 1 | Serial controller select |
| serial_rs | output | 2 | Serial controller register index |
| preg_cs | output | 1 | Peripheral register select |
| bridge_en | output | 1 | RAM-side to CPU data bus bridge enable |

## Verification
The window is tested with reads and writes in three register states: RAM unprotected, RAM protected and ROM mode. These show the output enable apart from the write strobe and separate the protect flag from the source bit. The bank is loaded with values that have both high and low bits set, and the value used on the next window access shows whether the load takes effect in time and whether only the low four data bits reach the latch. Boundary addresses at the edges of each range, odd and even bridge addresses, and register reads check that the decode is exact and that reads never load a register. Window writes sampled in the low phase check that the write strobe is qualified by the clock.

// File: rtl/bw_pkg.sv
package bw_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int BANK_W   = 4;
  localparam int ROM_SOCK = 4;

  typedef struct packed {
    logic                xram_cs;
    logic                xram_oe;
    logic                xram_wr;
    logic                winrom_cs;
    logic [ROM_SOCK-1:0] mbrom;
    logic [ROM_SOCK-1:0] exprom;
    logic                serial_cs;
    logic                preg_cs;
    logic                bridge_en;
  } sel_t;

  typedef enum logic [1:0] {
    SRC_RAM_OPEN = 2'b00,
    SRC_RAM_WP   = 2'b10,
    SRC_ROM      = 2'b01,
    SRC_ROM_WP   = 2'b11
  } win_mode_e;
endpackage

// File: rtl/bw_rst_sync.sv
module bw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], 1'b1};
  end

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/bw_ctrl_regs.sv
module bw_ctrl_regs
  import bw_pkg::*;
#(
  parameter int BANK_BITS = BANK_W,
  parameter int DBITS     = DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bank_wr,
  input  logic                 ctrl_wr,
  input  logic [DBITS-1:0]     wdata,
  output logic [BANK_BITS-1:0] bank_q,
  output win_mode_e            mode_q
);
  logic [BANK_BITS-1:0] bank_d;
  win_mode_e            mode_d;
  logic                 unused_bits;

  always_comb begin
    bank_d = bank_q;
    mode_d = mode_q;
    if (bank_wr) bank_d = wdata[BANK_BITS-1:0];
    if (ctrl_wr) mode_d = win_mode_e'({wdata[1], wdata[0]});
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      mode_q <= SRC_RAM_OPEN;
    end else begin
      if (bank_wr) bank_q <= bank_d;
      if (ctrl_wr) mode_q <= mode_d;
    end
  end

  assign unused_bits = ^wdata[DBITS-1:BANK_BITS];

  // R2: a bank write is visible from the next falling edge on
  p_bank_load_r2: assert property (@(negedge clk) disable iff (!rst_n)
    bank_wr |=> (bank_q == $past(wdata[BANK_BITS-1:0])));

  // R11: without a strobe the registers hold
  p_hold_r11: assert property (@(negedge clk) disable iff (!rst_n)
    (!bank_wr && !ctrl_wr) |=> ($stable(bank_q) && $stable(mode_q)));
endmodule

// File: rtl/bw_addr_decode.sv
module bw_addr_decode
  import bw_pkg::*;
#(
  parameter int       NSOCK     = ROM_SOCK,
  parameter logic [3:0] WIN_PAGE  = 4'h9,
  parameter logic [3:0] ROM_PAGE0 = 4'hA,
  parameter logic [7:0] IO_PAGE   = 8'hEF,
  parameter logic [7:0] BANK_OFS  = 8'hFC,
  parameter logic [7:0] CTRL_OFS  = 8'hFE,
  parameter logic [7:0] PREG_OFS  = 8'hF0,
  parameter logic [7:0] SER_OFS   = 8'hF8,
  parameter logic [3:0] BRG_NIB   = 4'hE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              rom_dis_n,
  input  win_mode_e         mode,
  output sel_t              sel,
  output logic              bank_wr,
  output logic              ctrl_wr
);
  logic [3:0] page;
  logic [7:0] lo;
  logic       win_hit;
  logic       io_hit;
  logic       rom_src;
  logic       wprot;
  logic [NSOCK-1:0] sock_hit;

  assign page    = addr[15:12];
  assign lo      = addr[7:0];
  assign win_hit = (page == WIN_PAGE);
  assign io_hit  = (addr[15:8] == IO_PAGE);
  assign rom_src = mode[0];
  assign wprot   = mode[1];

  for (genvar g = 0; g < NSOCK; g++) begin : g_sock
    localparam logic [3:0] SOCK_PAGE = ROM_PAGE0 + 4'(g);
    assign sock_hit[g] = (page == SOCK_PAGE);
  end

  always_comb begin
    sel           = '0;
    sel.xram_cs   = win_hit && !rom_src;
    sel.xram_oe   = win_hit && !rom_src && !we;
    sel.xram_wr   = win_hit && !rom_src && we && !wprot;
    sel.winrom_cs = win_hit && rom_src;
    sel.mbrom     = rom_dis_n ? sock_hit : '0;
    sel.exprom    = rom_dis_n ? '0 : sock_hit;
    sel.preg_cs   = io_hit && (lo[7:2] == PREG_OFS[7:2]);
    sel.serial_cs = io_hit && (lo[7:2] == SER_OFS[7:2]);
    sel.bridge_en = io_hit && (lo[7:4] == BRG_NIB) && !lo[0];
  end

  assign bank_wr = we && io_hit && (lo == BANK_OFS);
  assign ctrl_wr = we && io_hit && (lo == CTRL_OFS);

  // R10: no two selects at once
  p_one_select_r10: assert property (@(negedge clk) disable iff (!rst_n)
    $onehot0({sel.xram_cs, sel.winrom_cs, sel.mbrom, sel.exprom,
              sel.serial_cs, sel.preg_cs, sel.bridge_en}));

  // R4: protected window never produces a RAM write
  p_wp_block_r4: assert property (@(negedge clk) disable iff (!rst_n)
    (mode == SRC_RAM_WP) |-> !sel.xram_wr);

  // R6: strap low silences motherboard ROMs
  p_rom_swap_r6: assert property (@(negedge clk) disable iff (!rst_n)
    !rom_dis_n |-> (sel.mbrom == '0));

  // R9: bridge only at even addresses of its row
  p_bridge_even_r9: assert property (@(negedge clk) disable iff (!rst_n)
    sel.bridge_en |-> (!addr[0] && addr[15:4] == {IO_PAGE, BRG_NIB}));

  // R5: read and write strobes exclusive
  p_oe_we_r5: assert property (@(negedge clk) disable iff (!rst_n)
    !(sel.xram_oe && sel.xram_wr));
endmodule

// File: rtl/bankwin_decoder.sv
module bankwin_decoder
  import bw_pkg::*;
#(
  parameter int NSOCK = ROM_SOCK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_we,
  input  logic [7:0]        cpu_wdata,
  input  logic              rom_dis_n,
  output logic [3:0]        xram_addr_hi,
  output logic              xram_cs,
  output logic              xram_oe,
  output logic              xram_we,
  output logic              winrom_cs,
  output logic [NSOCK-1:0]  mbrom_cs,
  output logic [NSOCK-1:0]  exprom_cs,
  output logic              serial_cs,
  output logic [1:0]        serial_rs,
  output logic              preg_cs,
  output logic              bridge_en
);
  logic      rst_sync_n;
  logic      bank_wr;
  logic      ctrl_wr;
  logic [BANK_W-1:0] bank_q;
  win_mode_e mode_q;
  sel_t      sel;

  bw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bw_addr_decode #(.NSOCK(NSOCK)) u_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .addr      (cpu_addr),
    .we        (cpu_we),
    .rom_dis_n (rom_dis_n),
    .mode      (mode_q),
    .sel       (sel),
    .bank_wr   (bank_wr),
    .ctrl_wr   (ctrl_wr)
  );

  bw_ctrl_regs #(.BANK_BITS(BANK_W), .DBITS(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .bank_wr (bank_wr),
    .ctrl_wr (ctrl_wr),
    .wdata   (cpu_wdata),
    .bank_q  (bank_q),
    .mode_q  (mode_q)
  );

  assign xram_addr_hi = bank_q;
  assign xram_cs      = sel.xram_cs;
  assign xram_oe      = sel.xram_oe;
  assign xram_we      = sel.xram_wr & clk;
  assign winrom_cs    = sel.winrom_cs;
  assign mbrom_cs     = sel.mbrom;
  assign exprom_cs    = sel.exprom;
  assign serial_cs    = sel.serial_cs;
  assign serial_rs    = cpu_addr[1:0];
  assign preg_cs      = sel.preg_cs;
  assign bridge_en    = sel.bridge_en;

  // R3: ROM source keeps the RAM deselected
  p_rom_mode_r3: assert property (@(negedge clk) disable iff (!rst_sync_n)
    mode_q[0] |-> (!xram_cs && !xram_oe));

  // R1: reset values of the registers
  p_reset_state_r1: assert property (@(negedge clk)
    !rst_sync_n |-> (bank_q == '0 && mode_q == SRC_RAM_OPEN));
endmodule

// File: tb/sim_bankwin_decoder.sv
module sim_bankwin_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_we = 1'b0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        rom_dis_n = 1'b1;
  logic [3:0]  xram_addr_hi;
  logic        xram_cs, xram_oe, xram_we, winrom_cs;
  logic [3:0]  mbrom_cs, exprom_cs;
  logic        serial_cs, preg_cs, bridge_en;
  logic [1:0]  serial_rs;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  bankwin_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .rom_dis_n(rom_dis_n), .xram_addr_hi(xram_addr_hi),
    .xram_cs(xram_cs), .xram_oe(xram_oe), .xram_we(xram_we),
    .winrom_cs(winrom_cs), .mbrom_cs(mbrom_cs), .exprom_cs(exprom_cs),
    .serial_cs(serial_cs), .serial_rs(serial_rs), .preg_cs(preg_cs),
    .bridge_en(bridge_en)
  );

  // sel = {xram_cs, xram_oe, xram_we, winrom_cs, mbrom[3:0], exprom[3:0], serial, preg, bridge}
  // vector = {addr16, we1, data8, strap1, sel15, hi4, req4}
  function automatic logic [48:0] v(input logic [15:0] a, input logic w,
      input logic [7:0] d, input logic s, input logic [14:0] e,
      input logic [3:0] h, input logic [3:0] r);
    return {a, w, d, s, e, h, r};
  endfunction

  localparam int NV = 36;
  localparam logic [48:0] VEC [NV] = '{
    v(16'h9123, 0, 8'h00, 1, 15'b110_0_0000_0000_000, 4'h0, 4'd1),  // R1
    v(16'hEFFC, 1, 8'hA5, 1, 15'b000_0_0000_0000_000, 4'h0, 4'd10), // R10 register addr
    v(16'h9FFF, 0, 8'h00, 1, 15'b110_0_0000_0000_000, 4'h5, 4'd2),  // R2
    v(16'h9000, 1, 8'h11, 1, 15'b101_0_0000_0000_000, 4'h5, 4'd5),  // R5
    v(16'hEFFC, 0, 8'h07, 1, 15'b000_0_0000_0000_000, 4'h5, 4'd11), // R11 read
    v(16'h9000, 0, 8'h00, 1, 15'b110_0_0000_0000_000, 4'h5, 4'd11),
    v(16'hEFFE, 1, 8'h02, 1, 15'b000_0_0000_0000_000, 4'h5, 4'd4),  // R4 set wp
    v(16'h9001, 1, 8'h22, 1, 15'b100_0_0000_0000_000, 4'h5, 4'd4),
    v(16'h9001, 0, 8'h00, 1, 15'b110_0_0000_0000_000, 4'h5, 4'd4),
    v(16'hEFFE, 0, 8'h01, 1, 15'b000_0_0000_0000_000, 4'h5, 4'd11), // R11 read ctrl
    v(16'h9002, 1, 8'h00, 1, 15'b100_0_0000_0000_000, 4'h5, 4'd11),
    v(16'hEFFE, 1, 8'h01, 1, 15'b000_0_0000_0000_000, 4'h5, 4'd3),  // R3 ROM mode
    v(16'h9800, 0, 8'h00, 1, 15'b000_1_0000_0000_000, 4'h5, 4'd3),
    v(16'h9800, 1, 8'h33, 1, 15'b000_1_0000_0000_000, 4'h5, 4'd3),
    v(16'hA000, 0, 8'h00, 1, 15'b000_0_0001_0000_000, 4'h5, 4'd6),  // R6
    v(16'hDFFF, 0, 8'h00, 1, 15'b000_0_1000_0000_000, 4'h5, 4'd6),
    v(16'hC000, 0, 8'h00, 0, 15'b000_0_0000_0100_000, 4'h5, 4'd6),
    v(16'hBFFF, 0, 8'h00, 0, 15'b000_0_0000_0010_000, 4'h5, 4'd6),
    v(16'hEFF0, 0, 8'h00, 1, 15'b000_0_0000_0000_010, 4'h5, 4'd7),  // R7
    v(16'hEFF3, 1, 8'h00, 1, 15'b000_0_0000_0000_010, 4'h5, 4'd7),
    v(16'hEFF8, 0, 8'h00, 1, 15'b000_0_0000_0000_100, 4'h5, 4'd8),  // R8
    v(16'hEFFB, 0, 8'h00, 1, 15'b000_0_0000_0000_100, 4'h5, 4'd8),
    v(16'hEFE0, 0, 8'h00, 1, 15'b000_0_0000_0000_001, 4'h5, 4'd9),  // R9
    v(16'hEFEE, 0, 8'h00, 1, 15'b000_0_0000_0000_001, 4'h5, 4'd9),
    v(16'hEFE1, 0, 8'h00, 1, 15'b000_0_0000_0000_000, 4'h5, 4'd9),
    v(16'hEFDE, 0, 8'h00, 1, 15'b000_0_0000_0000_000, 4'h5, 4'd9),
    v(16'h0000, 0, 8'h00, 1, 15'b000_0_0000_0000_000, 4'h5, 4'd10), // R10
    v(16'h8FFF, 0, 8'h00, 1, 15'b000_0_0000_0000_000, 4'h5, 4'd10),
    v(16'hEFF4, 0, 8'h00, 1, 15'b000_0_0000_0000_000, 4'h5, 4'd10),
    v(16'hE000, 0, 8'h00, 1, 15'b000_0_0000_0000_000, 4'h5, 4'd10),
    v(16'hF000, 0, 8'h00, 0, 15'b000_0_0000_0000_000, 4'h5, 4'd10),
    v(16'hEFFE, 1, 8'h00, 1, 15'b000_0_0000_0000_000, 4'h5, 4'd3),  // R3 back to RAM
    v(16'h9ABC, 1, 8'h00, 1, 15'b101_0_0000_0000_000, 4'h5, 4'd3),
    v(16'hEFFC, 1, 8'hFA, 1, 15'b000_0_0000_0000_000, 4'h5, 4'd2),  // R2 upper bits dropped
    v(16'h9000, 0, 8'h00, 1, 15'b110_0_0000_0000_000, 4'hA, 4'd2),
    v(16'h9FFF, 0, 8'h00, 1, 15'b110_0_0000_0000_000, 4'hA, 4'd2)
  };

  function automatic logic [14:0] got_sel();
    return {xram_cs, xram_oe, xram_we, winrom_cs, mbrom_cs, exprom_cs,
            serial_cs, preg_cs, bridge_en};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive just after a rising edge, sample in the high phase
  task automatic cycle(input logic [15:0] a, input logic w, input logic [7:0] d, input logic s);
    @(posedge clk);
    #1;
    cpu_addr = a; cpu_we = w; cpu_wdata = d; rom_dis_n = s;
    #2;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #10 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [48:0] e;
      e = VEC[i];
      cycle(e[48:33], e[32], e[31:24], e[23]);
      check($sformatf("R%0d vec%0d sel", e[3:0], i), 32'(got_sel()), 32'(e[22:8]));
      if (e[22]) check($sformatf("R%0d vec%0d bank", e[3:0], i), 32'(xram_addr_hi), 32'(e[7:4]));
      // R8: register index follows A1:A0
      check($sformatf("R8 vec%0d rs", i), 32'(serial_rs), 32'(e[34:33]));
    end

    // R5: write strobe low during the low clock phase
    cycle(16'h9100, 1'b1, 8'h00, 1'b1);
    check("R5 we high phase", 32'(xram_we), 32'd1);
    @(negedge clk); #2;
    check("R5 we low phase", 32'(xram_we), 32'd0);
    check("R5 cs low phase", 32'(xram_cs), 32'd1);

    // R1: reset in mid-run restores bank 0, RAM source, no protection
    cycle(16'hEFFE, 1'b1, 8'h03, 1'b1);
    cycle(16'h0000, 1'b0, 8'h00, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R1 async clear bank", 32'(xram_addr_hi), 32'd0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    cycle(16'h9555, 1'b0, 8'h00, 1'b1);
    check("R1 read after reset", 32'(got_sel()), 32'(15'b110_0_0000_0000_000));
    check("R1 bank after reset", 32'(xram_addr_hi), 32'd0);
    cycle(16'h9555, 1'b1, 8'h00, 1'b1);
    check("R1 write unprotected", 32'(got_sel()), 32'(15'b101_0_0000_0000_000));

    // R2: bank write followed immediately by a window access
    cycle(16'hEFFC, 1'b1, 8'h03, 1'b1);
    cycle(16'h9000, 1'b0, 8'h00, 1'b1);
    check("R2 next cycle bank", 32'(xram_addr_hi), 32'd3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule